// File: doc/BRIEF.md
# Daisy-Chain Serial Frame Processor

This block is the command front end of one chip in a linear chain of serial devices. Bits arrive on an upstream port, one per strobe, together with a select line that marks the words of a host frame. Every bit leaves on a downstream port exactly sixteen bit times later. While a word sits in that sixteen-bit line, the block can replace it before it leaves. Every frame starts with a header word: the upper byte is the command and the lower byte is a target address. Address zero reaches every chip, and any other value reaches only the chip that holds it.

Chips number themselves. An enumeration frame carries a running count in its second word. Each chip takes the count plus one as its own address and writes that value back into the word it forwards. The host therefore receives the last chip's address. Each chip also holds a 48-bit register image. The upper 24 bits are writable, the middle 16 bits always read as zero, and the low byte reports the number of healthy engines. A read request is answered inside the passing stream: the addressed chip rewrites the header and fills the three words that follow. A reset command sends a one-cycle clear pulse to the engine side and keeps both the address and the configuration.

Top module: `chain_frame_proc`

## Requirements
- R1: Bits move from the upstream data/select pair to the downstream pair with a delay of exactly 16 strobes, and are unchanged unless another requirement rewrites the word. The outputs hold their value in cycles without a strobe.
- R2: `out_en` is `in_en` delayed by one clock.
- R3: A header of command 0x01 with address 0x00 is followed by one word. The chip takes that word's low byte plus one as its address, saturating at 0xFF, and forwards the word as 0x00 followed by the new address.
- R4: After reset `node_id` is 0x00, `cfg_bits` equals the parameter `CFG_RST` (default 0x0A4C21), and `out_en` and `engine_clear` are low.
- R5: A header of command 0x09 addressed to 0x00 or to the chip's own nonzero address is followed by three words. The first word goes to register bits 47:32, the second to 31:16 and the third to 15:0. The writable field `cfg_bits` = bits 47:24. All four words are forwarded unchanged.
- R6: A command-0x09 frame for another address leaves `cfg_bits` unchanged. Its three payload words are skipped and never decoded as headers, even when they have select high.
- R7: A header of command 0x0A with the chip's own nonzero address leaves as 0x1A followed by the address. The next three words on the line are replaced by register bits 47:32, 31:16 and 15:0, in that order.
- R8: Register bits 23:8 read as zero whatever was written, and bits 7:0 read the `good_cnt` input.
- R9: A header of command 0x04 addressed to 0x00 or to the chip's own address produces a single-cycle `engine_clear` pulse. `node_id` and `cfg_bits` are kept, and the header is forwarded unchanged. A 0x04 header for another address produces no pulse.
- R10: A read header with address 0x00 or with an address that no chip holds passes through unchanged, with nothing inserted.
- R11: Outside a frame, a new header is recognised only when its first bit arrives with select high. Words sent with select low are forwarded and never decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_en | input | 1 | Upstream bit strobe |
| in_sel | input | 1 | Upstream select, high during host frame words |
| in_dat | input | 1 | Upstream serial data, MSB first |
| good_cnt | input | CNT_W | Healthy engine count shown in register bits 7:0 |
| out_en | output | 1 | Downstream bit strobe |
| out_sel | output | 1 | Downstream select |
| out_dat | output | 1 | Downstream serial data |
| node_id | output | 8 | Address held by this chip |
| cfg_bits | output | CFG_W | Writable register field, bits 47:24 |
| engine_clear | output | 1 | One-cycle clear pulse to the engine side |

## Verification
The hardest situation to reach is an in-stream substitution that must coexist with other traffic. A read answer is written over words the host sends with select low, and it has to pass untouched through the chips further down the chain, which must not decode the 0x1A header or the register data as commands. Three instances are therefore connected in series. The host's read requests go to the first, middle and last chip in turn, with random idle cycles between strobes. Individual writes whose payload looks like a reset header check that skipped words are never decoded. Address saturation is reached by seeding the enumeration count at 0xFD.

// File: rtl/cfp_pkg.sv
package cfp_pkg;

    // Frame geometry is fixed by the wire protocol
    localparam int WORD_W = 16;
    localparam int CMD_W  = 8;
    localparam int ADR_W  = WORD_W - CMD_W;

    localparam logic [CMD_W-1:0] CMD_ENUM     = 8'h01;
    localparam logic [CMD_W-1:0] CMD_RESET    = 8'h04;
    localparam logic [CMD_W-1:0] CMD_WRITE    = 8'h09;
    localparam logic [CMD_W-1:0] CMD_READ     = 8'h0A;
    localparam logic [CMD_W-1:0] CMD_READ_ACK = 8'h1A;

    typedef enum logic [2:0] {
        MD_IDLE,
        MD_HDR,
        MD_ENUM,
        MD_WRITE,
        MD_READ,
        MD_SKIP
    } mode_e;

    // Request to replace the word completing on the line
    typedef struct packed {
        logic              en;
        logic [WORD_W-1:0] word;
    } subst_t;

    function automatic logic [ADR_W-1:0] next_addr(input logic [ADR_W-1:0] a);
        return (a == {ADR_W{1'b1}}) ? a : a + 1'b1;
    endfunction

endpackage

// File: rtl/cfp_pipe.sv
module cfp_pipe
    import cfp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              in_sel,
    input  logic              in_dat,
    input  subst_t            subst,
    output logic [WORD_W-1:0] word_nxt,
    output logic              out_en,
    output logic              out_sel,
    output logic              out_dat
);

    logic [WORD_W-1:0] dat_line;
    logic [WORD_W-1:0] sel_line;

    // Word as it stands once the incoming bit has been shifted in
    assign word_nxt = {dat_line[WORD_W-2:0], in_dat};

    always_ff @(posedge clk) begin
        if (rst) begin
            dat_line <= '0;
            sel_line <= '0;
            out_en   <= 1'b0;
            out_sel  <= 1'b0;
            out_dat  <= 1'b0;
        end else begin
            out_en <= bit_en;
            if (bit_en) begin
                out_dat  <= dat_line[WORD_W-1];
                out_sel  <= sel_line[WORD_W-1];
                dat_line <= subst.en ? subst.word : word_nxt;
                sel_line <= {sel_line[WORD_W-2:0], in_sel};
            end
        end
    end

endmodule

// File: rtl/cfp_cfg.sv
module cfp_cfg
    import cfp_pkg::*;
#(
    parameter int REG_WORDS = 3,
    parameter int CFG_W     = 24,
    parameter int RSV_W     = 16,
    parameter int CNT_W     = 8,
    parameter logic [CFG_W-1:0] CFG_RST = 24'h0A4C21,
    localparam int REG_W    = WORD_W * REG_WORDS,
    localparam int IDX_W    = (REG_WORDS > 1) ? $clog2(REG_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    output logic [CFG_W-1:0]  cfg_bits
);

    localparam int LAST = REG_WORDS - 1;

    logic [CFG_W-1:0] commit_val;

    // Each writable bit knows which payload word and which bit of it feed it
    for (genvar j = 0; j < CFG_W; j++) begin : g_bit
        localparam int POS = RSV_W + CNT_W + j;
        localparam int WI  = (REG_W - 1 - POS) / WORD_W;
        localparam int BI  = POS % WORD_W;
        if (WI == LAST) begin : g_direct
            assign commit_val[j] = wr_word[BI];
        end else begin : g_staged
            logic held;
            always_ff @(posedge clk) begin
                if (rst) begin
                    held <= 1'b0;
                end else if (wr_en && wr_idx == IDX_W'(WI)) begin
                    held <= wr_word[BI];
                end
            end
            assign commit_val[j] = held;
        end
    end

    // Register takes the new image only when the final word lands
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_bits <= CFG_RST;
        end else if (wr_en && wr_idx == IDX_W'(LAST)) begin
            cfg_bits <= commit_val;
        end
    end

endmodule

// File: rtl/cfp_ctrl.sv
module cfp_ctrl
    import cfp_pkg::*;
#(
    parameter int REG_WORDS = 3,
    localparam int REG_W    = WORD_W * REG_WORDS,
    localparam int IDX_W    = (REG_WORDS > 1) ? $clog2(REG_WORDS) : 1,
    localparam int LEFT_W   = $clog2(REG_WORDS + 1),
    localparam int BC_W     = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              in_sel,
    input  logic [WORD_W-1:0] word_nxt,
    input  logic [REG_W-1:0]  reg_image,
    output subst_t            subst,
    output logic              wr_en,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [WORD_W-1:0] wr_word,
    output logic [ADR_W-1:0]  node_id,
    output logic              clr_pulse
);

    mode_e             mode_q, mode_d;
    logic [BC_W-1:0]   bcnt_q, bcnt_d;
    logic [LEFT_W-1:0] left_q, left_d;
    logic [IDX_W-1:0]  widx_q, widx_d;
    logic [ADR_W-1:0]  node_q, node_d;
    logic              clr_q, clr_d;

    logic [CMD_W-1:0]  cmd;
    logic [ADR_W-1:0]  adr;
    logic              done, bcast, mine;

    assign cmd   = word_nxt[WORD_W-1 -: CMD_W];
    assign adr   = word_nxt[ADR_W-1:0];
    assign bcast = (adr == '0);
    assign mine  = (adr == node_q) && (node_q != '0);
    assign done  = bit_en && (mode_q != MD_IDLE) && (bcnt_q == BC_W'(WORD_W - 1));

    always_comb begin
        mode_d     = mode_q;
        bcnt_d     = bcnt_q;
        left_d     = left_q;
        widx_d     = widx_q;
        node_d     = node_q;
        clr_d      = 1'b0;
        subst      = '0;
        wr_en      = 1'b0;
        wr_idx     = widx_q;
        wr_word    = word_nxt;

        if (bit_en) begin
            if (mode_q == MD_IDLE) begin
                if (in_sel) begin
                    mode_d = MD_HDR;
                    bcnt_d = BC_W'(1);
                end
            end else begin
                bcnt_d = done ? '0 : bcnt_q + 1'b1;
            end
        end

        if (done) begin
            unique case (mode_q)
                MD_HDR: begin
                    mode_d = MD_IDLE;
                    widx_d = '0;
                    if (cmd == CMD_ENUM && bcast) begin
                        mode_d = MD_ENUM;
                        left_d = LEFT_W'(1);
                    end else if (cmd == CMD_WRITE) begin
                        mode_d = (bcast || mine) ? MD_WRITE : MD_SKIP;
                        left_d = LEFT_W'(REG_WORDS);
                    end else if (cmd == CMD_READ && mine) begin
                        subst.en   = 1'b1;
                        subst.word = {CMD_READ_ACK, adr};
                        mode_d     = MD_READ;
                        left_d     = LEFT_W'(REG_WORDS);
                    end else if (cmd == CMD_RESET && (bcast || mine)) begin
                        clr_d = 1'b1;
                    end
                end
                MD_ENUM: begin
                    node_d     = next_addr(adr);
                    subst.en   = 1'b1;
                    subst.word = {{CMD_W{1'b0}}, next_addr(adr)};
                    mode_d     = MD_IDLE;
                end
                MD_WRITE, MD_READ, MD_SKIP: begin
                    if (mode_q == MD_WRITE) begin
                        wr_en = 1'b1;
                    end
                    if (mode_q == MD_READ) begin
                        subst.en   = 1'b1;
                        subst.word = reg_image[REG_W - 1 - int'(widx_q) * WORD_W -: WORD_W];
                    end
                    widx_d = widx_q + 1'b1;
                    if (left_q == LEFT_W'(1)) begin
                        mode_d = MD_IDLE;
                    end else begin
                        left_d = left_q - 1'b1;
                    end
                end
                default: mode_d = MD_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MD_IDLE;
            bcnt_q <= '0;
            left_q <= '0;
            widx_q <= '0;
            node_q <= '0;
            clr_q  <= 1'b0;
        end else begin
            mode_q <= mode_d;
            bcnt_q <= bcnt_d;
            left_q <= left_d;
            widx_q <= widx_d;
            node_q <= node_d;
            clr_q  <= clr_d;
        end
    end

    assign node_id   = node_q;
    assign clr_pulse = clr_q;

endmodule

// File: rtl/chain_frame_proc.sv
module chain_frame_proc
    import cfp_pkg::*;
#(
    parameter int REG_WORDS = 3,
    parameter int CFG_W     = 24,
    parameter int RSV_W     = 16,
    parameter int CNT_W     = 8,
    parameter logic [CFG_W-1:0] CFG_RST = 24'h0A4C21,
    localparam int REG_W    = WORD_W * REG_WORDS,
    localparam int IDX_W    = (REG_WORDS > 1) ? $clog2(REG_WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_en,
    input  logic             in_sel,
    input  logic             in_dat,
    input  logic [CNT_W-1:0] good_cnt,
    output logic             out_en,
    output logic             out_sel,
    output logic             out_dat,
    output logic [ADR_W-1:0] node_id,
    output logic [CFG_W-1:0] cfg_bits,
    output logic             engine_clear
);

    subst_t            subst;
    logic [WORD_W-1:0] word_nxt;
    logic              wr_en;
    logic [IDX_W-1:0]  wr_idx;
    logic [WORD_W-1:0] wr_word;
    logic [REG_W-1:0]  reg_image;

    assign reg_image = {cfg_bits, {RSV_W{1'b0}}, good_cnt};

    cfp_pipe u_pipe (
        .clk      (clk),
        .rst      (rst),
        .bit_en   (in_en),
        .in_sel   (in_sel),
        .in_dat   (in_dat),
        .subst    (subst),
        .word_nxt (word_nxt),
        .out_en   (out_en),
        .out_sel  (out_sel),
        .out_dat  (out_dat)
    );

    cfp_ctrl #(
        .REG_WORDS (REG_WORDS)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .bit_en    (in_en),
        .in_sel    (in_sel),
        .word_nxt  (word_nxt),
        .reg_image (reg_image),
        .subst     (subst),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_word   (wr_word),
        .node_id   (node_id),
        .clr_pulse (engine_clear)
    );

    cfp_cfg #(
        .REG_WORDS (REG_WORDS),
        .CFG_W     (CFG_W),
        .RSV_W     (RSV_W),
        .CNT_W     (CNT_W),
        .CFG_RST   (CFG_RST)
    ) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_word  (wr_word),
        .cfg_bits (cfg_bits)
    );

endmodule

// File: rtl/cfp_chk.sv
module cfp_chk #(
    parameter int ADR_W = 8,
    parameter int CFG_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             in_en,
    input logic             out_en,
    input logic             out_sel,
    input logic             out_dat,
    input logic             engine_clear,
    input logic [ADR_W-1:0] node_id,
    input logic [CFG_W-1:0] cfg_bits
);

    assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (rst)
        in_en |=> out_en);

    assert_strobe_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !in_en |=> !out_en);

    assert_line_holds_R1: assert property (@(posedge clk) disable iff (rst)
        !in_en |=> ($stable(out_dat) && $stable(out_sel)));

    assert_addr_moves_on_bit_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(node_id) |-> $past(in_en));

    assert_cfg_moves_on_bit_R5: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg_bits) |-> $past(in_en));

    assert_clear_single_R9: assert property (@(posedge clk) disable iff (rst)
        engine_clear |=> !engine_clear);

    assert_clear_on_bit_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(engine_clear) |-> $past(in_en));

endmodule

bind chain_frame_proc cfp_chk #(
    .ADR_W (cfp_pkg::ADR_W),
    .CFG_W (CFG_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_en        (in_en),
    .out_en       (out_en),
    .out_sel      (out_sel),
    .out_dat      (out_dat),
    .engine_clear (engine_clear),
    .node_id      (node_id),
    .cfg_bits     (cfg_bits)
);

// File: tb/chain_frame_proc_test.sv
module chain_frame_proc_test;

    localparam logic [23:0] DEF_CFG = 24'h0A4C21;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst;
    logic h_en, h_sel, h_dat;
    logic e1, s1, d1, e2, s2, d2, e3, s3, d3;
    logic [7:0]  id0, id1, id2;
    logic [23:0] cf0, cf1, cf2;
    logic        cl0, cl1, cl2;

    chain_frame_proc uut (
        .clk(clk), .rst(rst), .in_en(h_en), .in_sel(h_sel), .in_dat(h_dat),
        .good_cnt(8'd32), .out_en(e1), .out_sel(s1), .out_dat(d1),
        .node_id(id0), .cfg_bits(cf0), .engine_clear(cl0));

    chain_frame_proc nxt1 (
        .clk(clk), .rst(rst), .in_en(e1), .in_sel(s1), .in_dat(d1),
        .good_cnt(8'd31), .out_en(e2), .out_sel(s2), .out_dat(d2),
        .node_id(id1), .cfg_bits(cf1), .engine_clear(cl1));

    chain_frame_proc nxt2 (
        .clk(clk), .rst(rst), .in_en(e2), .in_sel(s2), .in_dat(d2),
        .good_cnt(8'd20), .out_en(e3), .out_sel(s3), .out_dat(d3),
        .node_id(id2), .cfg_bits(cf2), .engine_clear(cl2));

    int n_vec = 0;
    int n_bad = 0;

    // Host-side receiver
    logic rx_b [0:16383];
    logic rx_s [0:16383];
    int   rx_n = 0;
    int   clrs [3] = '{0, 0, 0};

    always @(negedge clk) begin
        if (e3 && rx_n < 16384) begin
            rx_b[rx_n] = d3;
            rx_s[rx_n] = s3;
            rx_n = rx_n + 1;
        end
        if (cl0) clrs[0]++;
        if (cl1) clrs[1]++;
        if (cl2) clrs[2]++;
    end

    logic [15:0] tw [0:7];
    logic        ts [0:7];
    int          tn;
    int          base;
    logic        gaps;

    logic [23:0] mcfg [3];
    logic [7:0]  mid  [3];
    logic [7:0]  mgood [3] = '{8'd32, 8'd31, 8'd20};

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] idk(int k);
        return (k == 0) ? id0 : (k == 1) ? id1 : id2;
    endfunction

    function automatic logic [23:0] cfk(int k);
        return (k == 0) ? cf0 : (k == 1) ? cf1 : cf2;
    endfunction

    function automatic logic [15:0] rxw(int w);
        logic [15:0] r = '0;
        for (int i = 0; i < 16; i++) r = {r[14:0], rx_b[base + 48 + w * 16 + i]};
        return r;
    endfunction

    function automatic logic [15:0] rxs(int w);
        logic [15:0] r = '0;
        for (int i = 0; i < 16; i++) r = {r[14:0], rx_s[base + 48 + w * 16 + i]};
        return r;
    endfunction

    function automatic logic [7:0] pick_cmd();
        logic [7:0] c = 8'h00;
        do c = 8'($urandom % 256);
        while (c == 8'h01 || c == 8'h04 || c == 8'h09 || c == 8'h0A);
        return c;
    endfunction

    task automatic send();
        base = rx_n;
        for (int w = 0; w < tn + 3; w++) begin
            logic [15:0] word = (w < tn) ? tw[w] : 16'h0000;
            logic        sel  = (w < tn) ? ts[w] : 1'b0;
            for (int b = 15; b >= 0; b--) begin
                if (gaps && ($urandom % 4 == 0)) begin
                    @(negedge clk);
                    h_en = 1'b0;
                end
                @(negedge clk);
                h_en  = 1'b1;
                h_dat = word[b];
                h_sel = sel;
            end
        end
        @(negedge clk);
        h_en = 1'b0; h_sel = 1'b0; h_dat = 1'b0;
        repeat (6) @(negedge clk);
        chk("R2 strobe count", 64'(rx_n - base), 64'((tn + 3) * 16));
    endtask

    task automatic do_write(input logic [7:0] adr, input logic [15:0] w1, w2, w3, input string tag);
        tn = 4;
        tw[0] = {8'h09, adr}; tw[1] = w1; tw[2] = w2; tw[3] = w3;
        for (int i = 0; i < 4; i++) ts[i] = 1'b1;
        send();
        for (int i = 0; i < 4; i++) chk({tag, " write echo"}, rxw(i), tw[i]);
        for (int k = 0; k < 3; k++) begin
            if (adr == 8'h00 || adr == mid[k]) mcfg[k] = {w1, w2[15:8]};
            chk({tag, " cfg"}, cfk(k), mcfg[k]);
        end
    endtask

    task automatic do_read(input int k);
        logic [7:0] adr = mid[k];
        tn = 4;
        tw[0] = {8'h0A, adr}; tw[1] = 16'h0; tw[2] = 16'h0; tw[3] = 16'h0;
        ts[0] = 1'b1; ts[1] = 1'b0; ts[2] = 1'b0; ts[3] = 1'b0;
        send();
        chk("R7 read header", rxw(0), {8'h1A, adr});
        chk("R7 read word 47:32", rxw(1), mcfg[k][23:8]);
        chk("R8 read word 31:16 reserved low byte", rxw(2), {mcfg[k][7:0], 8'h00});
        chk("R8 read word 15:0 good count", rxw(3), {8'h00, mgood[k]});
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL R2 watchdog act=running exp=finished");
        summary();
        $finish;
    end

    initial begin
        int c0, c1, c2;
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; h_en = 1'b0; h_sel = 1'b0; h_dat = 1'b0; gaps = 1'b0;
        for (int k = 0; k < 3; k++) begin mcfg[k] = DEF_CFG; mid[k] = 8'h00; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R4 reset state
        for (int k = 0; k < 3; k++) begin
            chk("R4 node_id", idk(k), 8'h00);
            chk("R4 cfg_bits", cfk(k), DEF_CFG);
        end
        chk("R4 out_en", e3, 1'b0);
        chk("R4 engine_clear", {cl0, cl1, cl2}, 3'b000);

        // R11 enumeration pattern with select low is not decoded
        tn = 2; tw[0] = 16'h0100; tw[1] = 16'h0000; ts[0] = 1'b0; ts[1] = 1'b0;
        send();
        chk("R11 word0 forwarded", rxw(0), 16'h0100);
        chk("R11 word1 forwarded", rxw(1), 16'h0000);
        for (int k = 0; k < 3; k++) chk("R11 node_id untouched", idk(k), 8'h00);

        // R3 enumeration
        ts[0] = 1'b1;
        send();
        chk("R3 enum header", rxw(0), 16'h0100);
        chk("R3 enum last address", rxw(1), 16'h0003);
        for (int k = 0; k < 3; k++) chk("R3 node_id", idk(k), 8'(k + 1));

        // R3 saturation at 0xFF
        tw[1] = 16'h00FD;
        send();
        chk("R3 saturated last", rxw(1), 16'h00FF);
        chk("R3 sat id0", id0, 8'hFE);
        chk("R3 sat id1", id1, 8'hFF);
        chk("R3 sat id2", id2, 8'hFF);
        tw[1] = 16'h0000;
        send();
        for (int k = 0; k < 3; k++) begin
            mid[k] = 8'(k + 1);
            chk("R3 re-enumerated", idk(k), mid[k]);
        end

        // R5 broadcast write, R8 reserved bits written as ones
        do_write(8'h00, 16'hC3A5, 16'h5AFF, 16'hFFFF, "R5");
        for (int k = 0; k < 3; k++) do_read(k);

        // R6 individual write: payload that looks like a reset header is skipped
        c0 = clrs[0]; c1 = clrs[1]; c2 = clrs[2];
        do_write(8'h02, 16'h0400, 16'h0400, 16'h0400, "R6");
        chk("R6 no clear chip0", 64'(clrs[0] - c0), 64'd0);
        chk("R6 no clear chip2", 64'(clrs[2] - c2), 64'd0);
        do_write(8'h09, 16'h1111, 16'h2222, 16'h3333, "R6");
        for (int k = 0; k < 3; k++) do_read(k);

        // R10 read with broadcast and unknown addresses
        tn = 4; ts[0] = 1'b1; ts[1] = 1'b0; ts[2] = 1'b0; ts[3] = 1'b0;
        tw[0] = 16'h0A00; tw[1] = 16'h0; tw[2] = 16'h0; tw[3] = 16'h0;
        send();
        for (int i = 0; i < 4; i++) chk("R10 broadcast read passes", rxw(i), tw[i]);
        tw[0] = 16'h0A09;
        send();
        for (int i = 0; i < 4; i++) chk("R10 unknown read passes", rxw(i), tw[i]);

        // R9 reset command, broadcast then individual
        c0 = clrs[0]; c1 = clrs[1]; c2 = clrs[2];
        tn = 1; tw[0] = 16'h0400; ts[0] = 1'b1;
        send();
        chk("R9 echo", rxw(0), 16'h0400);
        chk("R9 pulses", {32'(clrs[0] - c0), 32'(clrs[1] - c1)}, {32'd1, 32'd1});
        chk("R9 pulse chip2", 64'(clrs[2] - c2), 64'd1);
        for (int k = 0; k < 3; k++) begin
            chk("R9 node kept", idk(k), mid[k]);
            chk("R9 cfg kept", cfk(k), mcfg[k]);
        end
        c0 = clrs[0]; c1 = clrs[1]; c2 = clrs[2];
        tw[0] = 16'h0402;
        send();
        chk("R9 individual pulses", {32'(clrs[0] - c0), 32'(clrs[1] - c1)}, {32'd0, 32'd1});
        chk("R9 individual chip2", 64'(clrs[2] - c2), 64'd0);

        // Random mix with strobe gaps
        gaps = 1'b1;
        for (int it = 0; it < 14; it++) begin
            int kind = int'($urandom % 3);
            if (kind == 0) begin
                tn = 1 + int'($urandom % 4);
                tw[0] = {pick_cmd(), 8'($urandom % 256)};
                ts[0] = 1'b1;
                for (int i = 1; i < tn; i++) begin
                    tw[i] = {pick_cmd(), 8'($urandom % 256)};
                    ts[i] = 1'b1;
                end
                send();
                for (int i = 0; i < tn; i++) begin
                    chk("R1 random word passes", rxw(i), tw[i]);
                    chk("R1 random select passes", rxs(i), 16'hFFFF);
                end
                chk("R1 pad select low", rxs(tn), 16'h0000);
            end else if (kind == 1) begin
                do_write(8'($urandom % 5), 16'($urandom), 16'($urandom), 16'($urandom), "R5");
                do_read(int'($urandom % 3));
            end else begin
                do_read(int'($urandom % 3));
            end
        end

        summary();
        $finish;
    end

endmodule